// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

A single DMA channel that copies a run of equally sized elements between one fixed device address and a memory buffer. A descriptor has four words: device address, memory address, size (element width and element count) and next (link pointer plus two flag bits). Software fills a four-word register bank through a small write port. It then picks a channel mode and a direction, and pulses `startReq` while the channel is idle.

In single-descriptor mode the channel copies the register bank into its working descriptor and runs it. In linked mode it treats the bank's next word as a pointer and fetches a descriptor from memory. It runs that descriptor and follows each link until it reaches a descriptor marked as the last one. Every element costs one read and one write on a request/acknowledge bus master port. A malformed descriptor stops the channel with an error pulse and no data traffic. Setting the mode to disabled aborts any activity.

Top module: `lnkdma_channel`

## Requirements
- R1: Register write word select `regWrSel` maps 0 to device address, 1 to memory address, 2 to size and 3 to next. A write changes only the register bank and never the descriptor the channel is running.
- R2: `chanMode` 2 runs the register-bank descriptor. `chanMode` 1 fetches a descriptor from memory at the next pointer with bits 1:0 cleared. It reads the words at pointer +0, +4, +8 and +12 in that order (device, memory, size, next), as 4-byte bus reads. `chanMode` 3 does not start the channel.
- R3: In the next word, bit 1 set means follow the link to another descriptor and bit 0 set means interrupt on completion. The link address is the word with bits 1:0 cleared.
- R4: Size bits 13:12 set the element width: 11 is 1 byte, 10 is 2 bytes, 00 is 4 bytes. Code 01 is illegal. `busWidth` reports 0 for 1 byte, 1 for 2 bytes and 2 for 4 bytes, and reports 2 during descriptor fetches. Bus data is right-justified.
- R5: Size bits 11:0 hold the element count. The limit is 0x3FF for 1-byte and 2-byte widths and 0x7FF for 4-byte width. An illegal width or an over-limit count gives a one-cycle `errP` and a return to idle, with no data access.
- R6: With `chanDirToDev`=1 each element is read at the memory address and written to the device address. With 0 it is read at the device address and written to memory. Direction is sampled at start.
- R7: The device address stays fixed for a whole descriptor. The memory address rises by the element width after each element.
- R8: `chanState` reads 0 idle, 1 descriptor fetch, 2 waiting (descriptor check), 3 data access. A start is taken only in idle, and a start pulse while busy has no effect.
- R9: `chanMode`=0 returns the channel to idle on the next clock, with `busReq` low.
- R10: When a descriptor completes, `irqP` pulses for one cycle if its interrupt flag is set. `doneP` pulses once when a descriptor without the follow flag completes. A zero count completes with no data access.
- R11: `busReq` and `busAddr` stay stable until `busAck` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register bank write strobe |
| regWrSel | input | 2 | Descriptor word select |
| regWrData | input | 32 | Register write data |
| chanMode | input | 2 | 0 disabled, 1 linked, 2 single, 3 reserved |
| chanDirToDev | input | 1 | 1 memory to device, 0 device to memory |
| startReq | input | 1 | Start pulse |
| busReq | output | 1 | Bus access request |
| busWe | output | 1 | Bus access is a write |
| busAddr | output | 32 | Bus byte address |
| busWidth | output | 2 | Access width code |
| busWdata | output | 32 | Write data, right-justified |
| busRdata | input | 32 | Read data, right-justified |
| busAck | input | 1 | Access completed this cycle |
| chanState | output | 2 | Channel state |
| doneP | output | 1 | Transfer finished pulse |
| irqP | output | 1 | Descriptor interrupt pulse |
| errP | output | 1 | Bad descriptor pulse |

## Verification
Single-descriptor runs use random widths, counts, directions, memory offsets and interrupt flags. Comparing device logs and memory contents against bench-computed element sequences separates faults in address stepping from faults in direction steering and width masking. A three-descriptor chain with mixed widths and flags checks the link walk, the interrupt count and the exact bus transaction count. Directed cases cover the count limits on each side, the illegal width code, zero count, reserved mode, a start pulse while busy and an abort. Each of these gives a distinct outcome in error pulses, done pulses and bus traffic.

// File: rtl/lnkdma_pkg.sv
package lnkdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DESC   = 2'd1,
    ST_WAIT   = 2'd2,
    ST_ACCESS = 2'd3
  } chanState_e;

  localparam logic [1:0] MODE_OFF    = 2'd0;
  localparam logic [1:0] MODE_LINKED = 2'd1;
  localparam logic [1:0] MODE_SINGLE = 2'd2;

  localparam logic [1:0] WCODE_1B = 2'b11;
  localparam logic [1:0] WCODE_2B = 2'b10;
  localparam logic [1:0] WCODE_4B = 2'b00;

  localparam int DW_DEV  = 0;
  localparam int DW_MEM  = 1;
  localparam int DW_SIZE = 2;
  localparam int DW_NEXT = 3;

  typedef struct packed {
    logic       loadRegs;
    logic       fetchInitReg;
    logic       fetchInitChain;
    logic       fetchCapture;
    logic [1:0] fetchIdx;
    logic       initCount;
    logic       readCapture;
    logic       stepElem;
    logic       fetchSel;
    logic       writePhase;
    logic       dirToDev;
  } dpCtl_t;
endpackage

// File: rtl/lnkdma_datapath.sv
module lnkdma_datapath
  import lnkdma_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [WORD_W-1:0] regWrData,
  input  dpCtl_t            ctl,
  input  logic [WORD_W-1:0] busRdata,
  output logic [WORD_W-1:0] busAddr,
  output logic [WORD_W-1:0] busWdata,
  output logic [1:0]        busWidth,
  output logic              descValid,
  output logic              isFollow,
  output logic              irqFlag,
  output logic              countZero,
  output logic              lastElem
);
  localparam int NWORDS = 4;
  localparam logic [CNT_W-1:0] LIMIT_NARROW = CNT_W'(12'h3FF);
  localparam logic [CNT_W-1:0] LIMIT_WIDE   = CNT_W'(12'h7FF);

  logic [WORD_W-1:0] regBank [NWORDS];
  logic [WORD_W-1:0] wDesc   [NWORDS];
  logic [WORD_W-1:0] fetchPtr, dataHold, elemMask, widthBytes;
  logic [CNT_W-1:0]  countLeft, sizeCount, countLimit;
  logic [1:0]        widthCode, widthEnc;
  logic              memSide;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) regBank[i] <= '0;
    end else if (regWrEn) begin
      regBank[regWrSel] <= regWrData;
    end
  end

  assign widthCode = wDesc[DW_SIZE][13:12];
  assign sizeCount = wDesc[DW_SIZE][CNT_W-1:0];

  always_comb begin
    unique case (widthCode)
      WCODE_1B: begin widthBytes = WORD_W'(1); elemMask = WORD_W'(32'hFF);   widthEnc = 2'd0; end
      WCODE_2B: begin widthBytes = WORD_W'(2); elemMask = WORD_W'(32'hFFFF); widthEnc = 2'd1; end
      default:  begin widthBytes = WORD_W'(4); elemMask = '1;                widthEnc = 2'd2; end
    endcase
    countLimit = (widthCode == WCODE_4B) ? LIMIT_WIDE : LIMIT_NARROW;
  end

  assign descValid = (widthCode != 2'b01) && (sizeCount <= countLimit);
  assign countZero = (sizeCount == '0);
  assign lastElem  = (countLeft == CNT_W'(1));
  assign isFollow  = wDesc[DW_NEXT][1];
  assign irqFlag   = wDesc[DW_NEXT][0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NWORDS; i++) wDesc[i] <= '0;
      fetchPtr  <= '0;
      countLeft <= '0;
      dataHold  <= '0;
    end else begin
      if (ctl.loadRegs)
        for (int i = 0; i < NWORDS; i++) wDesc[i] <= regBank[i];
      if (ctl.fetchCapture) wDesc[ctl.fetchIdx] <= busRdata;
      if (ctl.fetchInitReg)   fetchPtr <= {regBank[DW_NEXT][WORD_W-1:2], 2'b00};
      if (ctl.fetchInitChain) fetchPtr <= {wDesc[DW_NEXT][WORD_W-1:2], 2'b00};
      if (ctl.initCount)   countLeft <= sizeCount;
      if (ctl.readCapture) dataHold  <= busRdata & elemMask;
      if (ctl.stepElem) begin
        countLeft      <= countLeft - CNT_W'(1);
        wDesc[DW_MEM]  <= wDesc[DW_MEM] + widthBytes;
      end
    end
  end

  // memory side is the source when copying toward the device
  assign memSide  = ctl.dirToDev ^ ctl.writePhase;
  assign busAddr  = ctl.fetchSel ? (fetchPtr + {{(WORD_W-4){1'b0}}, ctl.fetchIdx, 2'b00})
                                 : (memSide ? wDesc[DW_MEM] : wDesc[DW_DEV]);
  assign busWidth = ctl.fetchSel ? 2'd2 : widthEnc;
  assign busWdata = dataHold;

  assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepElem |-> (countLeft != '0));
  assert_dev_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepElem |=> $stable(wDesc[DW_DEV]));
  assert_mem_advance_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.stepElem |=> (wDesc[DW_MEM] - $past(wDesc[DW_MEM]) == $past(widthBytes)));
endmodule

// File: rtl/lnkdma_control.sv
module lnkdma_control
  import lnkdma_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] chanMode,
  input  logic       chanDirToDev,
  input  logic       startReq,
  input  logic       busAck,
  input  logic       descValid,
  input  logic       isFollow,
  input  logic       irqFlag,
  input  logic       countZero,
  input  logic       lastElem,
  output dpCtl_t     ctl,
  output logic       busReq,
  output logic       busWe,
  output logic [1:0] chanState,
  output logic       doneP,
  output logic       irqP,
  output logic       errP
);
  chanState_e state;
  logic [1:0] fetchIdx;
  logic       writePhase, dirQ, descDone, active;

  assign active = (chanMode != MODE_OFF);
  assign busReq = (state == ST_DESC) || (state == ST_ACCESS);
  assign busWe  = (state == ST_ACCESS) && writePhase;
  assign chanState = state;

  assign descDone = ((state == ST_WAIT) && descValid && countZero) ||
                    ((state == ST_ACCESS) && busAck && writePhase && lastElem);

  always_comb begin
    ctl = '0;
    ctl.loadRegs       = (state == ST_IDLE) && startReq && (chanMode == MODE_SINGLE);
    ctl.fetchInitReg   = (state == ST_IDLE) && startReq && (chanMode == MODE_LINKED);
    ctl.fetchInitChain = descDone && isFollow;
    ctl.fetchCapture   = (state == ST_DESC) && busAck && active;
    ctl.fetchIdx       = fetchIdx;
    ctl.initCount      = (state == ST_WAIT) && descValid && !countZero;
    ctl.readCapture    = (state == ST_ACCESS) && busAck && !writePhase && active;
    ctl.stepElem       = (state == ST_ACCESS) && busAck && writePhase && active;
    ctl.fetchSel       = (state == ST_DESC);
    ctl.writePhase     = writePhase;
    ctl.dirToDev       = dirQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE; fetchIdx <= '0; writePhase <= 1'b0; dirQ <= 1'b0;
      doneP <= 1'b0; irqP <= 1'b0; errP <= 1'b0;
    end else begin
      doneP <= 1'b0; irqP <= 1'b0; errP <= 1'b0;
      if (!active) begin
        state <= ST_IDLE;
        writePhase <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (startReq && chanMode == MODE_LINKED) begin
              state <= ST_DESC; fetchIdx <= '0; dirQ <= chanDirToDev;
            end else if (startReq && chanMode == MODE_SINGLE) begin
              state <= ST_WAIT; dirQ <= chanDirToDev;
            end
          end
          ST_DESC: if (busAck) begin
            if (fetchIdx == 2'd3) state <= ST_WAIT;
            fetchIdx <= fetchIdx + 2'd1;
          end
          ST_WAIT: begin
            if (!descValid) begin
              errP <= 1'b1; state <= ST_IDLE;
            end else if (!countZero) begin
              state <= ST_ACCESS; writePhase <= 1'b0;
            end
          end
          ST_ACCESS: if (busAck) writePhase <= !writePhase;
        endcase
        if (descDone) begin
          irqP <= irqFlag;
          if (isFollow) begin
            state <= ST_DESC; fetchIdx <= '0;
          end else begin
            doneP <= 1'b1; state <= ST_IDLE;
          end
        end
      end
    end
  end

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    (chanMode == MODE_OFF) |=> (state == ST_IDLE));
  assert_start_taken_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && (chanMode == MODE_LINKED || chanMode == MODE_SINGLE))
      |=> (state != ST_IDLE));
  assert_err_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    errP |-> !$past(busReq));
  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(doneP && errP));
endmodule

// File: rtl/lnkdma_channel.sv
module lnkdma_channel
  import lnkdma_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [1:0]        regWrSel,
  input  logic [WORD_W-1:0] regWrData,
  input  logic [1:0]        chanMode,
  input  logic              chanDirToDev,
  input  logic              startReq,
  output logic              busReq,
  output logic              busWe,
  output logic [WORD_W-1:0] busAddr,
  output logic [1:0]        busWidth,
  output logic [WORD_W-1:0] busWdata,
  input  logic [WORD_W-1:0] busRdata,
  input  logic              busAck,
  output logic [1:0]        chanState,
  output logic              doneP,
  output logic              irqP,
  output logic              errP
);
  dpCtl_t ctl;
  logic descValid, isFollow, irqFlag, countZero, lastElem;

  lnkdma_control u_ctrl (
    .clk(clk), .rstN(rstN), .chanMode(chanMode), .chanDirToDev(chanDirToDev),
    .startReq(startReq), .busAck(busAck), .descValid(descValid), .isFollow(isFollow),
    .irqFlag(irqFlag), .countZero(countZero), .lastElem(lastElem), .ctl(ctl),
    .busReq(busReq), .busWe(busWe), .chanState(chanState),
    .doneP(doneP), .irqP(irqP), .errP(errP)
  );

  lnkdma_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .ctl(ctl), .busRdata(busRdata), .busAddr(busAddr),
    .busWdata(busWdata), .busWidth(busWidth), .descValid(descValid),
    .isFollow(isFollow), .irqFlag(irqFlag), .countZero(countZero), .lastElem(lastElem)
  );

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busAck && chanMode != 2'd0) |=> (busReq && $stable(busAddr) && $stable(busWe)));
endmodule

// File: tb/tb_lnkdma_channel.sv
`timescale 1ns/1ps
module tb_lnkdma_channel;
  localparam logic [31:0] DEV_ADDR = 32'h0000_8010;

  logic clk = 0, rstN = 0;
  logic regWrEn = 0; logic [1:0] regWrSel = 0; logic [31:0] regWrData = 0;
  logic [1:0] chanMode = 0; logic chanDirToDev = 0; logic startReq = 0;
  logic busReq, busWe; logic [31:0] busAddr, busWdata; logic [1:0] busWidth;
  logic [31:0] busRdata = 0; logic busAck = 0;
  logic [1:0] chanState; logic doneP, irqP, errP;

  always #10 clk = ~clk;

  lnkdma_channel dut (.*);

  logic [7:0]  mem [4096];
  logic [31:0] devLog [2048];
  logic [31:0] devRdLog [2048];
  int devN, devRdN, busTxns, devAddrBad, waitCnt;
  int doneCnt, irqCnt, errCnt;
  logic [3:0] stateSeen;
  logic [31:0] devSeq = 32'h1234_5678;
  int tests = 0, fails = 0;

  function automatic int wBytes(logic [1:0] enc);
    return enc == 2'd0 ? 1 : (enc == 2'd1 ? 2 : 4);
  endfunction
  function automatic int codeBytes(logic [1:0] code);
    return code == 2'b11 ? 1 : (code == 2'b10 ? 2 : 4);
  endfunction
  function automatic logic [31:0] maskOf(int w);
    return w == 1 ? 32'hFF : (w == 2 ? 32'hFFFF : 32'hFFFF_FFFF);
  endfunction
  function automatic logic [31:0] memElem(logic [31:0] a, int w);
    logic [31:0] v = 0;
    for (int i = 0; i < w; i++) v[8*i +: 8] = mem[(a + i) & 32'hFFF];
    return v;
  endfunction

  // bus responder and monitors, acting between clock edges
  always @(negedge clk) begin
    if (doneP) doneCnt++;
    if (irqP) irqCnt++;
    if (errP) errCnt++;
    stateSeen[chanState] = 1'b1;
    if (busAck) busAck = 0;
    else if (busReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        int w;
        w = wBytes(busWidth);
        busTxns++;
        if (busAddr[15]) begin
          if (busAddr != DEV_ADDR) devAddrBad++;
          if (busWe) begin devLog[devN] = busWdata & maskOf(w); devN++; end
          else begin
            busRdata = devSeq & maskOf(w);
            devRdLog[devRdN] = busRdata; devRdN++;
            devSeq = devSeq * 32'd1103515245 + 32'd12345;
          end
        end else if (busWe) begin
          for (int i = 0; i < w; i++) mem[(busAddr + i) & 32'hFFF] = busWdata[8*i +: 8];
        end else busRdata = memElem(busAddr, w);
        busAck = 1;
        waitCnt = $urandom % 3;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk); regWrEn = 1; regWrSel = sel; regWrData = val;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic startChan(input logic [1:0] mode, input logic dir);
    @(negedge clk); chanMode = mode; chanDirToDev = dir; startReq = 1;
    @(negedge clk); startReq = 0;
  endtask

  task automatic clearLogs();
    devN = 0; devRdN = 0; busTxns = 0; devAddrBad = 0; stateSeen = 0;
  endtask

  task automatic waitEnd(input int d0, input int e0);
    int n = 0;
    while (doneCnt == d0 && errCnt == e0 && n < 20000) begin @(negedge clk); n++; end
    chk(n < 20000, "R10", "transfer ended before timeout", n, 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic runSingle(input logic [1:0] code, input int count, input logic dir,
                           input logic [31:0] memA, input logic irq);
    int d0, i0, e0, w;
    w = codeBytes(code);
    clearLogs();
    for (int i = 0; i < count * w; i++) mem[(memA + i) & 32'hFFF] = 8'($urandom);
    wrReg(2'd0, DEV_ADDR);
    wrReg(2'd1, memA);
    wrReg(2'd2, {18'd0, code, count[11:0]});
    wrReg(2'd3, {31'd0, irq});
    d0 = doneCnt; i0 = irqCnt; e0 = errCnt;
    startChan(2'd2, dir);
    waitEnd(d0, e0);
    chk(doneCnt == d0 + 1, "R10", "single done pulse", doneCnt - d0, 1);
    chk(irqCnt == i0 + int'(irq), "R10", "single irq pulse", irqCnt - i0, irq);
    chk(errCnt == e0, "R5", "no error on legal size", errCnt - e0, 0);
    chk(devAddrBad == 0, "R7", "device address fixed", devAddrBad, 0);
    if (dir) begin
      chk(devN == count, "R6", "device writes", devN, count);
      for (int i = 0; i < count; i++)
        chk(devLog[i] == memElem(memA + i * w, w), "R7", "mem to dev element",
            devLog[i], memElem(memA + i * w, w));
    end else begin
      chk(devRdN == count, "R6", "device reads", devRdN, count);
      for (int i = 0; i < count; i++)
        chk(memElem(memA + i * w, w) == devRdLog[i], "R7", "dev to mem element",
            memElem(memA + i * w, w), devRdLog[i]);
    end
  endtask

  task automatic putWord(input logic [31:0] a, input logic [31:0] v);
    for (int i = 0; i < 4; i++) mem[(a + i) & 32'hFFF] = v[8*i +: 8];
  endtask

  task automatic badSize(input logic [1:0] code, input int count, input string req);
    int d0, e0;
    clearLogs();
    wrReg(2'd2, {18'd0, code, count[11:0]});
    wrReg(2'd3, 32'd0);
    d0 = doneCnt; e0 = errCnt;
    startChan(2'd2, 1'b1);
    waitEnd(d0, e0);
    chk(errCnt == e0 + 1, req, "error pulse", errCnt - e0, 1);
    chk(doneCnt == d0, req, "no done on error", doneCnt - d0, 0);
    chk(busTxns == 0, req, "no bus access on error", busTxns, 0);
    chk(chanState == 2'd0, "R8", "idle after error", chanState, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i * 7);
    waitCnt = 0; doneCnt = 0; irqCnt = 0; errCnt = 0; clearLogs();
    repeat (4) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk(chanState == 2'd0, "R8", "reset state idle", chanState, 0);
    chk(busReq == 0, "R11", "no request after reset", busReq, 0);
    chk(doneCnt + irqCnt + errCnt == 0, "R10", "no pulses after reset", doneCnt + irqCnt + errCnt, 0);

    // directed single-descriptor cases, one per width code (R1, R4, R6)
    runSingle(2'b11, 7, 1'b1, 32'h100, 1'b1);
    runSingle(2'b10, 5, 1'b0, 32'h182, 1'b0);
    runSingle(2'b00, 4, 1'b1, 32'h1C0, 1'b1);
    runSingle(2'b00, 3, 1'b0, 32'h1E4, 1'b0);
    // count limit edge accepted for narrow width (R5)
    runSingle(2'b11, 12'h3FF, 1'b1, 32'h400, 1'b0);

    // random single-descriptor traffic
    for (int k = 0; k < 10; k++) begin
      logic [1:0] code; int w;
      code = ($urandom % 3 == 0) ? 2'b11 : (($urandom % 2 == 0) ? 2'b10 : 2'b00);
      w = codeBytes(code);
      runSingle(code, 1 + ($urandom % 12), 1'($urandom), 32'h800 + (($urandom % 512) & ~(w - 1)),
                1'($urandom));
    end

    // illegal descriptors (R4, R5)
    badSize(2'b01, 4, "R4");
    badSize(2'b10, 12'h400, "R5");
    badSize(2'b11, 12'h400, "R5");
    badSize(2'b00, 12'h800, "R5");

    // zero count completes without bus traffic (R10)
    begin
      int d0;
      clearLogs();
      wrReg(2'd2, {18'd0, 2'b00, 12'd0});
      wrReg(2'd3, 32'd1);
      d0 = doneCnt;
      startChan(2'd2, 1'b1);
      waitEnd(d0, errCnt);
      chk(doneCnt == d0 + 1, "R10", "zero count done", doneCnt - d0, 1);
      chk(busTxns == 0, "R10", "zero count no access", busTxns, 0);
    end

    // reserved mode does not start (R2)
    begin
      int d0;
      clearLogs();
      wrReg(2'd2, {18'd0, 2'b00, 12'd2});
      d0 = doneCnt;
      startChan(2'd3, 1'b1);
      repeat (20) @(negedge clk);
      chk(busTxns == 0 && chanState == 2'd0, "R2", "reserved mode idle", busTxns, 0);
      chk(doneCnt == d0, "R2", "reserved mode no done", doneCnt - d0, 0);
    end

    // linked chain of three descriptors (R2, R3)
    begin
      int d0, i0, idx;
      for (int i = 0; i < 64; i++) mem[32'h300 + i] = 8'($urandom);
      putWord(32'h200, DEV_ADDR); putWord(32'h204, 32'h300);
      putWord(32'h208, {18'd0, 2'b11, 12'd5}); putWord(32'h20C, 32'h210 | 32'h2);
      putWord(32'h210, DEV_ADDR); putWord(32'h214, 32'h340);
      putWord(32'h218, {18'd0, 2'b10, 12'd3}); putWord(32'h21C, 32'h220 | 32'h3);
      putWord(32'h220, DEV_ADDR); putWord(32'h224, 32'h380);
      putWord(32'h228, {18'd0, 2'b00, 12'd2}); putWord(32'h22C, 32'h1);
      clearLogs();
      wrReg(2'd3, 32'h202);
      d0 = doneCnt; i0 = irqCnt;
      startChan(2'd1, 1'b1);
      waitEnd(d0, errCnt);
      chk(doneCnt == d0 + 1, "R3", "chain single done", doneCnt - d0, 1);
      chk(irqCnt == i0 + 2, "R3", "chain irq count", irqCnt - i0, 2);
      chk(busTxns == 32, "R2", "chain bus transactions", busTxns, 32);
      chk(stateSeen[1] && stateSeen[2] && stateSeen[3], "R8", "states visited", stateSeen, 4'hF);
      chk(devN == 10, "R3", "chain element count", devN, 10);
      idx = 0;
      for (int i = 0; i < 5; i++) begin
        chk(devLog[idx] == memElem(32'h300 + i, 1), "R3", "chain d0", devLog[idx], memElem(32'h300 + i, 1)); idx++;
      end
      for (int i = 0; i < 3; i++) begin
        chk(devLog[idx] == memElem(32'h340 + 2 * i, 2), "R3", "chain d1", devLog[idx], memElem(32'h340 + 2 * i, 2)); idx++;
      end
      for (int i = 0; i < 2; i++) begin
        chk(devLog[idx] == memElem(32'h380 + 4 * i, 4), "R3", "chain d2", devLog[idx], memElem(32'h380 + 4 * i, 4)); idx++;
      end
    end

    // start while busy is ignored; register rewrite does not disturb (R8, R1)
    begin
      int d0;
      clearLogs();
      wrReg(2'd0, DEV_ADDR); wrReg(2'd1, 32'h500);
      wrReg(2'd2, {18'd0, 2'b11, 12'd8}); wrReg(2'd3, 32'd0);
      d0 = doneCnt;
      startChan(2'd2, 1'b1);
      repeat (4) @(negedge clk);
      wrReg(2'd2, {18'd0, 2'b11, 12'd3});
      startReq = 1; @(negedge clk); startReq = 0;
      waitEnd(d0, errCnt);
      chk(devN == 8, "R8", "busy start ignored", devN, 8);
      chk(doneCnt == d0 + 1, "R8", "one done for busy start", doneCnt - d0, 1);
    end

    // abort: wide limit accepted, then disable (R5, R9)
    begin
      int e0;
      clearLogs();
      wrReg(2'd1, 32'h0); wrReg(2'd2, {18'd0, 2'b00, 12'h7FF}); wrReg(2'd3, 32'd0);
      e0 = errCnt;
      startChan(2'd2, 1'b1);
      repeat (30) @(negedge clk);
      chk(errCnt == e0, "R5", "0x7FF at 4 bytes accepted", errCnt - e0, 0);
      chk(chanState == 2'd3, "R8", "in data access", chanState, 3);
      chanMode = 2'd0;
      @(negedge clk);
      chk(chanState == 2'd0, "R9", "idle after disable", chanState, 0);
      chk(busReq == 0, "R9", "request dropped", busReq, 0);
      repeat (3) @(negedge clk);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule